// File: doc/BRIEF.md
# Block-Wise Bitonic Merge-Split Sorter

This block sorts sixteen 64-bit unsigned keys held in a local register array. The array is viewed as four blocks of four keys. A host fills the array through a single-entry write port and pulses `start`. The controller then sorts each block on its own with a 4-input bitonic sorting network. After that it treats whole blocks as the elements of a bitonic schedule over four positions. Each step of that schedule takes two sorted blocks and passes them through an 8-input bitonic merging network. The lower half of the merged result goes back to the first block of the pair and the upper half to the second. When the last step is written back, a one-cycle `done` pulse is issued. The sorted array can then be read through a combinational read port.

Both networks see the same operand register and produce a result in every cycle. A single controller picks which result is stored, so the two networks run in lockstep. Every step takes exactly three cycles. The states are IDLE, FETCH (copy the selected blocks into the operand register), CALC (register the chosen network output), STORE (write back) and FIN (signal completion). The transitions are as follows:
- IDLE goes to FETCH when `start` is high.
- FETCH goes to CALC, and CALC goes to STORE, with no condition.
- STORE goes to FETCH while steps remain, and to FIN after the tenth step.
- FIN goes to IDLE with no condition.

The merge steps use these block pairs, in this order: (0,1), (3,2), (0,2), (1,3), (0,1), (2,3). In each pair the first block receives the four smaller keys.

Top module: `block_bitonic_sorter`

## Requirements
- R1: After reset every array entry reads as zero and `done` is low.
- R2: While the block is idle, a high `host_we` at a clock edge writes `host_wkey` into entry `host_idx`. `rd_key` always shows entry `rd_idx` without any clock delay.
- R3: After a sort, entry 0 holds the smallest key and entries 0 to 15 are in non-decreasing order. Every write-back produces keys in ascending order, and a merge step always pairs two different blocks.
- R4: The sorted array is a permutation of the loaded keys. Keys that compare equal are neither lost nor duplicated, even when all keys are equal or only a few distinct values occur.
- R5: `done` is high for exactly one cycle. That cycle begins at the 30th rising edge after the edge that sampled `start` (four presort steps plus six merge steps, three cycles each).
- R6: A `start` pulse while a sort is running has no effect: the run neither restarts nor shifts its `done` cycle.
- R7: Host writes while a sort is running, including the `done` cycle, are ignored. The array changes only on write-back cycles.
- R8: Keys compare as unsigned 64-bit values, so a key with bit 63 set sorts above every key with bit 63 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sort; sampled only while idle |
| done | output | 1 | One-cycle completion pulse |
| host_we | input | 1 | Write strobe of the host write port |
| host_idx | input | 4 | Entry written by the host |
| host_wkey | input | 64 | Key written by the host |
| rd_idx | input | 4 | Entry shown on `rd_key` |
| rd_key | output | 64 | Combinational read data |

## Verification
Random 64-bit keys exercise the general compare paths. Reverse-ordered and already-ordered sets show whether the merge-split steps move whole blocks correctly in both directions. All-equal keys and sets drawn from only four values separate a correct permutation from one that drops or duplicates ties. A mix of keys with and without bit 63 catches a signed comparison. Two further runs inject a `start` pulse and a host write in the middle of a sort. These show that neither disturbs the timing of `done` or the contents of the array.

// File: rtl/blksort_pkg.sv
package blksort_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_CALC,
        S_STORE,
        S_FIN
    } sort_state_t;

    // Number of merge-split steps in a bitonic schedule over nblk blocks.
    function automatic int merge_step_count(input int nblk, input int lg);
        return (nblk / 2) * lg * (lg + 1) / 2;
    endfunction

    // Block pair for merge step k: [31:16] receives the low half, [15:0] the high half.
    function automatic logic [31:0] sched_pair(input int k, input int nblk, input int lg);
        int half;
        int sub;
        int j;
        int p_sel;
        int q_sel;
        int cnt;
        int i;
        int partner;
        logic [31:0] r;
        half  = nblk / 2;
        sub   = k / half;
        j     = k % half;
        p_sel = 1;
        q_sel = 0;
        cnt   = 0;
        for (int p = 1; p <= lg; p++) begin
            for (int r2 = 0; r2 < p; r2++) begin
                if (cnt == sub) begin
                    p_sel = p;
                    q_sel = p - 1 - r2;
                end
                cnt++;
            end
        end
        i       = ((j >> q_sel) << (q_sel + 1)) | (j & ((1 << q_sel) - 1));
        partner = i + (1 << q_sel);
        if (((i >> p_sel) & 1) == 0)
            r = {i[15:0], partner[15:0]};
        else
            r = {partner[15:0], i[15:0]};
        return r;
    endfunction

endpackage

// File: rtl/blksort_sortnet.sv
module blksort_sortnet #(
    parameter int KW = 64,
    parameter int N  = 4
) (
    input  logic [N-1:0][KW-1:0] din,
    output logic [N-1:0][KW-1:0] dout
);
    localparam int LG  = $clog2(N);
    localparam int NST = LG * (LG + 1) / 2;

    logic [KW-1:0] st [0:NST][0:N-1];

    for (genvar i = 0; i < N; i++) begin : g_in
        assign st[0][i] = din[i];
        assign dout[i]  = st[NST][i];
    end

    for (genvar p = 1; p <= LG; p++) begin : g_phase
        for (genvar r = 0; r < p; r++) begin : g_pass
            localparam int Q = p - 1 - r;
            localparam int D = 1 << Q;
            localparam int S = (p - 1) * p / 2 + r;
            for (genvar i = 0; i < N; i++) begin : g_lane
                if (((i >> Q) & 1) == 0) begin : g_cx
                    localparam bit UP = ((i >> p) & 1) == 0;
                    logic sw;
                    assign sw = (st[S][i] > st[S][i+D]) == UP;
                    assign st[S+1][i]   = sw ? st[S][i+D] : st[S][i];
                    assign st[S+1][i+D] = sw ? st[S][i]   : st[S][i+D];
                end
            end
        end
    end
endmodule

// File: rtl/blksort_mergenet.sv
module blksort_mergenet #(
    parameter int KW = 64,
    parameter int N  = 4
) (
    input  logic [N-1:0][KW-1:0]   lo_in,
    input  logic [N-1:0][KW-1:0]   hi_in,
    output logic [2*N-1:0][KW-1:0] dout
);
    localparam int N2 = 2 * N;
    localparam int LG = $clog2(N2);

    logic [KW-1:0] st [0:LG][0:N2-1];

    // Second run reversed so the eight inputs form one bitonic sequence.
    for (genvar i = 0; i < N; i++) begin : g_in
        assign st[0][i]     = lo_in[i];
        assign st[0][N + i] = hi_in[N-1-i];
    end

    for (genvar i = 0; i < N2; i++) begin : g_out
        assign dout[i] = st[LG][i];
    end

    for (genvar s = 0; s < LG; s++) begin : g_stage
        localparam int D = N2 >> (s + 1);
        for (genvar i = 0; i < N2; i++) begin : g_lane
            if (((i / D) % 2) == 0) begin : g_cx
                logic sw;
                assign sw = st[s][i] > st[s][i+D];
                assign st[s+1][i]   = sw ? st[s][i+D] : st[s][i];
                assign st[s+1][i+D] = sw ? st[s][i]   : st[s][i+D];
            end
        end
    end
endmodule

// File: rtl/blksort_ctrl.sv
module blksort_ctrl
    import blksort_pkg::*;
#(
    parameter int NBLK = 4,
    localparam int BW  = (NBLK > 1) ? $clog2(NBLK) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          busy,
    output logic          done,
    output logic          fetch,
    output logic          calc,
    output logic          store,
    output logic          is_merge,
    output logic [BW-1:0] blk_a,
    output logic [BW-1:0] blk_b
);
    localparam int LB    = $clog2(NBLK);
    localparam int NPRE  = NBLK;
    localparam int NMRG  = merge_step_count(NBLK, LB);
    localparam int NSTEP = NPRE + NMRG;
    localparam int SW    = $clog2(NSTEP + 1);
    localparam int RSZ   = 1 << SW;

    sort_state_t   state, nstate;
    logic [SW-1:0] step;
    logic [SW-1:0] mi;
    logic [BW-1:0] rom_a [RSZ];
    logic [BW-1:0] rom_b [RSZ];

    for (genvar m = 0; m < RSZ; m++) begin : g_rom
        if (m < NMRG) begin : g_used
            localparam logic [31:0] PR = sched_pair(m, NBLK, LB);
            assign rom_a[m] = PR[16 +: BW];
            assign rom_b[m] = PR[0 +: BW];
        end else begin : g_unused
            assign rom_a[m] = '0;
            assign rom_b[m] = '0;
        end
    end

    always_comb begin
        nstate = state;
        unique case (state)
            S_IDLE:  if (start) nstate = S_FETCH;
            S_FETCH: nstate = S_CALC;
            S_CALC:  nstate = S_STORE;
            S_STORE: nstate = (step == SW'(NSTEP - 1)) ? S_FIN : S_FETCH;
            S_FIN:   nstate = S_IDLE;
            default: nstate = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            step  <= '0;
        end else begin
            state <= nstate;
            if (state == S_IDLE)
                step <= '0;
            else if (state == S_STORE)
                step <= step + 1'b1;
        end
    end

    assign mi = step - SW'(NPRE);

    always_comb begin
        busy     = 1'b1;
        done     = 1'b0;
        fetch    = 1'b0;
        calc     = 1'b0;
        store    = 1'b0;
        unique case (state)
            S_IDLE:  busy  = 1'b0;
            S_FETCH: fetch = 1'b1;
            S_CALC:  calc  = 1'b1;
            S_STORE: store = 1'b1;
            S_FIN:   done  = 1'b1;
            default: busy  = 1'b0;
        endcase
        if (step < SW'(NPRE)) begin
            is_merge = 1'b0;
            blk_a    = BW'(step);
            blk_b    = BW'(step);
        end else begin
            is_merge = 1'b1;
            blk_a    = rom_a[mi];
            blk_b    = rom_b[mi];
        end
    end
endmodule

// File: rtl/block_bitonic_sorter.sv
module block_bitonic_sorter #(
    parameter int KEY_W    = 64,
    parameter int BLK_KEYS = 4,
    parameter int NUM_BLKS = 4,
    localparam int NUM_KEYS = BLK_KEYS * NUM_BLKS,
    localparam int IDX_W    = $clog2(NUM_KEYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             done,
    input  logic             host_we,
    input  logic [IDX_W-1:0] host_idx,
    input  logic [KEY_W-1:0] host_wkey,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [KEY_W-1:0] rd_key
);
    localparam int BW    = (NUM_BLKS > 1) ? $clog2(NUM_BLKS) : 1;
    localparam int LOGBK = $clog2(BLK_KEYS);

    logic [NUM_KEYS-1:0][KEY_W-1:0]   key_mem;
    logic [BLK_KEYS-1:0][KEY_W-1:0]   opnd_a, opnd_b, sort_out;
    logic [2*BLK_KEYS-1:0][KEY_W-1:0] mrg_out, res;
    logic                             busy, fetch, calc, store, is_merge;
    logic [BW-1:0]                    blk_a, blk_b;
    logic [IDX_W-1:0]                 base_a, base_b;

    blksort_ctrl #(.NBLK(NUM_BLKS)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .busy     (busy),
        .done     (done),
        .fetch    (fetch),
        .calc     (calc),
        .store    (store),
        .is_merge (is_merge),
        .blk_a    (blk_a),
        .blk_b    (blk_b)
    );

    blksort_sortnet #(.KW(KEY_W), .N(BLK_KEYS)) u_sort (
        .din  (opnd_a),
        .dout (sort_out)
    );

    blksort_mergenet #(.KW(KEY_W), .N(BLK_KEYS)) u_merge (
        .lo_in (opnd_a),
        .hi_in (opnd_b),
        .dout  (mrg_out)
    );

    assign base_a = {blk_a, {LOGBK{1'b0}}};
    assign base_b = {blk_b, {LOGBK{1'b0}}};
    assign rd_key = key_mem[rd_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opnd_a <= '0;
            opnd_b <= '0;
            res    <= '0;
        end else begin
            if (fetch) begin
                opnd_a <= key_mem[base_a +: BLK_KEYS];
                opnd_b <= key_mem[base_b +: BLK_KEYS];
            end
            if (calc)
                res <= is_merge ? mrg_out : {opnd_b, sort_out};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_mem <= '0;
        end else if (store) begin
            key_mem[base_a +: BLK_KEYS] <= res[BLK_KEYS-1:0];
            if (is_merge)
                key_mem[base_b +: BLK_KEYS] <= res[2*BLK_KEYS-1:BLK_KEYS];
        end else if (!busy && host_we) begin
            key_mem[host_idx] <= host_wkey;
        end
    end
endmodule

// File: rtl/blksort_checker.sv
module blksort_checker #(
    parameter int KEY_W    = 64,
    parameter int BLK_KEYS = 4,
    parameter int NUM_BLKS = 4,
    localparam int NUM_KEYS = BLK_KEYS * NUM_BLKS,
    localparam int BW       = (NUM_BLKS > 1) ? $clog2(NUM_BLKS) : 1
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             done,
    input logic                             busy,
    input logic                             store,
    input logic                             is_merge,
    input logic [BW-1:0]                    blk_a,
    input logic [BW-1:0]                    blk_b,
    input logic [2*BLK_KEYS-1:0][KEY_W-1:0] res,
    input logic [NUM_KEYS-1:0][KEY_W-1:0]   key_mem
);
    localparam int LB   = $clog2(NUM_BLKS);
    localparam int NSTP = NUM_BLKS + (NUM_BLKS / 2) * LB * (LB + 1) / 2;
    localparam int LAT  = 3 * NSTP;

    logic [15:0] run_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) run_cnt <= '0;
        else        run_cnt <= busy ? run_cnt + 1'b1 : '0;
    end

    function automatic bit ascending(input logic [2*BLK_KEYS-1:0][KEY_W-1:0] v, input int n);
        bit ok;
        ok = 1'b1;
        for (int i = 0; i < 2 * BLK_KEYS - 1; i++)
            if (i + 1 < n && v[i] > v[i+1]) ok = 1'b0;
        return ok;
    endfunction

    a_r3_store_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        store |-> ascending(res, is_merge ? 2 * BLK_KEYS : BLK_KEYS));

    a_r3_pair_distinct: assert property (@(posedge clk) disable iff (!rst_n)
        (store && is_merge) |-> (blk_a != blk_b));

    a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: a restart would break the fixed count checked here
    a_r5_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_cnt == 16'(LAT)));

    a_r7_mem_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !store) |=> (key_mem == $past(key_mem)));
endmodule

bind block_bitonic_sorter blksort_checker #(
    .KEY_W    (KEY_W),
    .BLK_KEYS (BLK_KEYS),
    .NUM_BLKS (NUM_BLKS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .done     (done),
    .busy     (busy),
    .store    (store),
    .is_merge (is_merge),
    .blk_a    (blk_a),
    .blk_b    (blk_b),
    .res      (res),
    .key_mem  (key_mem)
);

// File: tb/block_bitonic_sorter_test.sv
module block_bitonic_sorter_test;
    localparam int CLK_PERIOD = 10;
    localparam int NK         = 16;
    localparam int EXP_LAT    = 30;

    typedef logic [63:0] karr_t [NK];

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        done;
    logic        host_we = 1'b0;
    logic [3:0]  host_idx = '0;
    logic [63:0] host_wkey = '0;
    logic [3:0]  rd_idx = '0;
    logic [63:0] rd_key;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    block_bitonic_sorter uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .done      (done),
        .host_we   (host_we),
        .host_idx  (host_idx),
        .host_wkey (host_wkey),
        .rd_idx    (rd_idx),
        .rd_key    (rd_key)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic karr_t ref_sort(input karr_t a);
        karr_t r;
        logic [63:0] t;
        r = a;
        for (int i = 1; i < NK; i++)
            for (int j = i; j > 0; j--)
                if (r[j-1] > r[j]) begin
                    t = r[j]; r[j] = r[j-1]; r[j-1] = t;
                end
        return r;
    endfunction

    task automatic host_write(input int idx, input logic [63:0] key);
        @(negedge clk);
        host_we = 1'b1; host_idx = 4'(idx); host_wkey = key;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic read_at(input int idx, output logic [63:0] key);
        rd_idx = 4'(idx);
        #1;
        key = rd_key;
    endtask

    task automatic run_trial(input string req, input karr_t keys,
                             input bit poke_start, input bit poke_write);
        karr_t exp;
        logic [63:0] v;
        int first_done;
        int n_done;
        for (int i = 0; i < NK; i++) host_write(i, keys[i]);
        // R2: write port lands and read port is combinational
        read_at(0, v);  chk("R2", v, keys[0]);
        read_at(15, v); chk("R2", v, keys[15]);
        exp = ref_sort(keys);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        first_done = -1;
        n_done = 0;
        for (int c = 1; c <= 36; c++) begin
            if (poke_start && c == 9) start = 1'b1;
            if (poke_start && c == 10) start = 1'b0;
            if (poke_write && c == 12) begin host_we = 1'b1; host_idx = 4'd5; host_wkey = 64'hDEAD_BEEF_0BAD_F00D; end
            if (poke_write && c == 13) host_we = 1'b0;
            @(negedge clk);
            if (done) begin
                n_done++;
                if (first_done < 0) first_done = c;
                if (poke_write) begin host_we = 1'b1; host_idx = 4'd9; host_wkey = 64'h1; end
            end else if (poke_write && host_idx == 4'd9) begin
                host_we = 1'b0; host_idx = 4'd0;
            end
        end
        host_we = 1'b0;
        chk(poke_start ? "R6 done cycle" : "R5 done cycle", 64'(first_done), 64'(EXP_LAT));
        chk("R5 done width", 64'(n_done), 64'd1);
        for (int i = 0; i < NK; i++) begin
            read_at(i, v);
            chk({req, " R3 order"}, v, exp[i]);
        end
    endtask

    initial begin
        karr_t k;
        logic [63:0] v;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 done", {63'd0, done}, 64'd0);
        for (int i = 0; i < NK; i++) begin
            read_at(i, v);
            chk("R1 entry", v, 64'd0);
        end
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NK; i++) k[i] = {$urandom, $urandom};
        run_trial("R3 random", k, 1'b0, 1'b0);
        for (int i = 0; i < NK; i++) k[i] = {$urandom, $urandom};
        run_trial("R6 start mid-run", k, 1'b1, 1'b0);
        for (int i = 0; i < NK; i++) k[i] = {$urandom, $urandom};
        run_trial("R7 write mid-run", k, 1'b0, 1'b1);
        for (int i = 0; i < NK; i++) k[i] = 64'(NK - i) * 64'd1000;
        run_trial("R3 reversed", k, 1'b0, 1'b0);
        for (int i = 0; i < NK; i++) k[i] = 64'(i) * 64'd7 + 64'd3;
        run_trial("R3 presorted", k, 1'b0, 1'b0);
        for (int i = 0; i < NK; i++) k[i] = 64'h0123_4567_89AB_CDEF;
        run_trial("R4 all equal", k, 1'b0, 1'b0);
        for (int i = 0; i < NK; i++) k[i] = 64'($urandom % 4);
        run_trial("R4 few values", k, 1'b0, 1'b0);
        for (int i = 0; i < NK; i++)
            k[i] = (i % 2 == 0) ? {1'b1, 31'($urandom), $urandom} : {1'b0, 31'($urandom), $urandom};
        k[3] = 64'hFFFF_FFFF_FFFF_FFFF;
        k[6] = 64'd0;
        run_trial("R8 msb mix", k, 1'b0, 1'b0);
        for (int t = 0; t < 4; t++) begin
            for (int i = 0; i < NK; i++) k[i] = {$urandom, $urandom} >> ($urandom % 60);
            run_trial("R3 random", k, 1'b0, 1'b0);
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (finished) break;
        end
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule